// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block walks a circular chain of receive descriptors that live in a shared memory. The memory port is word addressed and has one cycle of read latency. Each descriptor takes four 32-bit words, in this order: link pointer (word 0), buffer pointer (word 1), command/status (word 2) and extended status (word 3). Descriptors sit on 16-byte boundaries.

Software prepares a descriptor by writing its buffer size (up to 4095 bytes, 1536 as a rule) into the command/status word with the ownership bit cleared. Before a frame arrives, the engine fetches the command/status word and then the link word of the current descriptor. When the receive path signals a finished frame, the engine writes the result back into the command/status word: length, status and the ownership bit. It then moves to the descriptor named by the link pointer.

The engine stops when it finds a descriptor whose ownership bit is already set. While stopped it drops frames. Only a start pulse makes it look again, and it resumes at the same descriptor. Payload copying and bus protocol are handled elsewhere.

Top module: `rx_desc_wb`

## Requirements
- R1: After reset the engine is stopped (`rx_running`=0, `rx_armed`=0) and issues no memory read or write until `rx_on` is pulsed.
- R2: The first `rx_on` after reset starts at the descriptor whose byte address is `ring_base`. The engine reads the command/status word (word address `ring_base/4 + 2`), then the link word (`ring_base/4`), and asserts `rx_armed` while it waits for a frame.
- R3: A frame taken while armed is written back to the command/status word with bit 31 (owned by software) = 1 and bit 28 = 0. Bit 29 (interrupt request) is kept from the armed word. Bits 11:0 hold `frame_len`, which already counts the 4 CRC bytes.
- R4: `frame_err` bits map to status bits as follows: [8]→26 abort, [7]→25 overrun, [6]→22 too long, [5]→21 runt, [4]→20 bad symbol, [3]→19 CRC, [2]→18 alignment, [1]→17 loopback, [0]→16 collision. Bits 24:23 and 15:12 are written 0.
- R5: Bit 27 (good frame) is 1 only when `frame_err[8:2]` is all zero and `frame_len` does not exceed the buffer size. A frame longer than the buffer sets bit 30 (more) and bit 22, clears bit 27, and reports the buffer size in bits 11:0. A frame exactly the buffer size is good.
- R6: After each writeback the engine follows the link word to the next descriptor. A four-descriptor ring whose last link points at the first therefore wraps.
- R7: When a fetched command/status word already has bit 31 set, the engine stops (`rx_running`=0). Every later `frame_done` pulses `rx_drop` one cycle later and writes nothing to memory.
- R8: `rx_on` while stopped resumes at the descriptor that stopped the engine, not at `ring_base`. `rx_on` while running has no effect.
- R9: `frame_done` while the engine is not armed (fetching or writing back) is dropped. `rx_drop` pulses on the following cycle and no descriptor is written for that frame.
- R10: The writeback write is issued in the cycle right after a frame is taken, and `rx_armed` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 32 | Byte address of the first descriptor (16-byte aligned) |
| rx_on | input | 1 | Start/resume pulse |
| frame_done | input | 1 | One-cycle frame-complete event |
| frame_len | input | 16 | Received byte count including CRC |
| frame_err | input | 9 | Error flags of the frame (mapping in R4) |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | 10 | Word address for the read or write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd_en` |
| rx_running | output | 1 | Engine not stopped |
| rx_armed | output | 1 | Descriptor held, frame can be taken |
| rx_drop | output | 1 | Pulse: a frame was discarded |

## Verification
Each result has a fixed due cycle. A start pulse leads to `rx_armed` four edges later. A taken frame reaches memory one edge after it is accepted. A dropped frame shows on `rx_drop` one edge after it is offered. The bench drives inputs on falling edges. After each frame it waits on falling edges until the engine is either armed again or stopped, bounded by a short limit, and only then reads the memory model. The fixed one-cycle timings are held by the bound checker.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

    localparam int WORD_W   = 32;
    localparam int SIZE_W   = 12;
    localparam int ERR_W    = 9;
    localparam int CMD_WORD = 2;   // command/status word index in a descriptor
    localparam int LINK_WORD = 0;  // link word index in a descriptor
    localparam int OWN_BIT  = 31;
    localparam int INTR_BIT = 29;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CMD,
        ST_CHK,
        ST_LINK,
        ST_ARMED,
        ST_WB
    } rx_state_e;

    typedef struct packed {
        logic abort;
        logic overrun;
        logic too_long;
        logic runt;
        logic bad_sym;
        logic crc;
        logic align;
        logic loopback;
        logic collision;
    } rx_err_t;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic [SIZE_W-1:0] size,
        input logic              more,
        input logic              intr,
        input logic              ok,
        input rx_err_t           e
    );
        logic [WORD_W-1:0] w;
        w        = '0;
        w[31]    = 1'b1;
        w[30]    = more;
        w[29]    = intr;
        w[28]    = 1'b0;
        w[27]    = ok;
        w[26]    = e.abort;
        w[25]    = e.overrun;
        w[22]    = e.too_long;
        w[21]    = e.runt;
        w[20]    = e.bad_sym;
        w[19]    = e.crc;
        w[18]    = e.align;
        w[17]    = e.loopback;
        w[16]    = e.collision;
        w[SIZE_W-1:0] = size;
        return w;
    endfunction

endpackage

// File: rtl/rxwb_status.sv
module rxwb_status
    import rxwb_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0]  byte_cnt,
    input  rx_err_t           err,
    input  logic [SIZE_W-1:0] buf_size,
    input  logic              intr,
    output logic [WORD_W-1:0] status_word
);

    logic    over;
    rx_err_t eff;
    logic    ok;
    logic [SIZE_W-1:0] size_out;

    always_comb begin
        over         = byte_cnt > LEN_W'(buf_size);
        eff          = err;
        eff.too_long = err.too_long | over;
        ok = !over && !(eff.abort | eff.overrun | eff.too_long | eff.runt |
                        eff.bad_sym | eff.crc | eff.align);
        size_out     = over ? buf_size : byte_cnt[SIZE_W-1:0];
        status_word  = pack_status(size_out, over, intr, ok, eff);
    end

endmodule

// File: rtl/rxwb_ptr.sv
module rxwb_ptr
    import rxwb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_base,
    input  logic [WORD_W-1:0] base,
    input  logic              take_link,
    input  logic [WORD_W-1:0] link_in,
    input  logic              follow,
    output logic              started,
    output logic [AW-1:0]     cmd_addr,
    output logic [AW-1:0]     link_addr
);

    logic [AW-1:0] cur_word;
    logic [AW-1:0] nxt_word;

    logic unused_ptr_bits;
    assign unused_ptr_bits = ^{base[WORD_W-1:AW+2], base[1:0],
                               link_in[WORD_W-1:AW+2], link_in[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_word <= '0;
            nxt_word <= '0;
            started  <= 1'b0;
        end else begin
            if (load_base) begin
                cur_word <= base[AW+1:2];
                started  <= 1'b1;
            end else if (follow) begin
                cur_word <= nxt_word;
            end
            if (take_link)
                nxt_word <= link_in[AW+1:2];
        end
    end

    assign cmd_addr  = cur_word + AW'(CMD_WORD);
    assign link_addr = cur_word + AW'(LINK_WORD);

endmodule

// File: rtl/rxwb_ctrl.sv
module rxwb_ctrl
    import rxwb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_on,
    input  logic frame_done,
    input  logic own_in,
    input  logic started,
    output logic rd_en,
    output logic sel_link,
    output logic wr_en,
    output logic load_base,
    output logic take_cmd,
    output logic take_link,
    output logic accept,
    output logic follow,
    output logic running,
    output logic armed,
    output logic drop
);

    rx_state_e state, state_n;

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:   if (rx_on) state_n = ST_RD_CMD;
            ST_RD_CMD: state_n = ST_CHK;
            ST_CHK:    state_n = own_in ? ST_IDLE : ST_LINK;
            ST_LINK:   state_n = ST_ARMED;
            ST_ARMED:  if (frame_done) state_n = ST_WB;
            ST_WB:     state_n = ST_RD_CMD;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            drop  <= 1'b0;
        end else begin
            state <= state_n;
            drop  <= frame_done && (state != ST_ARMED);
        end
    end

    always_comb begin
        rd_en     = (state == ST_RD_CMD) || (state == ST_CHK && !own_in);
        sel_link  = (state == ST_CHK);
        wr_en     = (state == ST_WB);
        load_base = (state == ST_IDLE) && rx_on && !started;
        take_cmd  = (state == ST_CHK) && !own_in;
        take_link = (state == ST_LINK);
        accept    = (state == ST_ARMED) && frame_done;
        follow    = (state == ST_WB);
        running   = (state != ST_IDLE);
        armed     = (state == ST_ARMED);
    end

endmodule

// File: rtl/rx_desc_wb.sv
module rx_desc_wb
    import rxwb_pkg::*;
#(
    parameter int AW    = 10,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] ring_base,
    input  logic              rx_on,
    input  logic              frame_done,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [ERR_W-1:0]  frame_err,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rx_running,
    output logic              rx_armed,
    output logic              rx_drop
);

    logic sel_link, load_base, take_cmd, take_link, accept, follow, started;
    logic [AW-1:0] cmd_addr, link_addr;

    logic [SIZE_W-1:0] buf_size;
    logic              intr_req;
    logic [LEN_W-1:0]  len_q;
    rx_err_t           err_q;

    rxwb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rx_on      (rx_on),
        .frame_done (frame_done),
        .own_in     (mem_rdata[OWN_BIT]),
        .started    (started),
        .rd_en      (mem_rd_en),
        .sel_link   (sel_link),
        .wr_en      (mem_wr_en),
        .load_base  (load_base),
        .take_cmd   (take_cmd),
        .take_link  (take_link),
        .accept     (accept),
        .follow     (follow),
        .running    (rx_running),
        .armed      (rx_armed),
        .drop       (rx_drop)
    );

    rxwb_ptr #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load_base (load_base),
        .base      (ring_base),
        .take_link (take_link),
        .link_in   (mem_rdata),
        .follow    (follow),
        .started   (started),
        .cmd_addr  (cmd_addr),
        .link_addr (link_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_size <= '0;
            intr_req <= 1'b0;
            len_q    <= '0;
            err_q    <= '0;
        end else begin
            if (take_cmd) begin
                buf_size <= mem_rdata[SIZE_W-1:0];
                intr_req <= mem_rdata[INTR_BIT];
            end
            if (accept) begin
                len_q <= frame_len;
                err_q <= rx_err_t'(frame_err);
            end
        end
    end

    rxwb_status #(.LEN_W(LEN_W)) u_status (
        .byte_cnt    (len_q),
        .err         (err_q),
        .buf_size    (buf_size),
        .intr        (intr_req),
        .status_word (mem_wdata)
    );

    assign mem_addr = sel_link ? link_addr : cmd_addr;

endmodule

// File: rtl/rx_desc_wb_chk.sv
module rx_desc_wb_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_done,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [31:0] mem_wdata,
    input logic        rx_running,
    input logic        rx_armed,
    input logic        rx_drop
);

    p_quiet_when_stopped_r1: assert property (@(posedge clk) disable iff (rst)
        !rx_running |-> (!mem_rd_en && !mem_wr_en));

    p_single_access_r2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    p_handover_own_r3: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_wdata[31] && !mem_wdata[28]));

    p_good_excl_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && (mem_wdata[30] || mem_wdata[22])) |-> !mem_wdata[27]);

    p_more_implies_long_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wdata[30]) |-> mem_wdata[22]);

    p_drop_when_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !rx_armed) |=> rx_drop);

    p_no_drop_when_armed_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_done && rx_armed) |=> !rx_drop);

    p_take_then_write_r10: assert property (@(posedge clk) disable iff (rst)
        (frame_done && rx_armed) |=> (mem_wr_en && !rx_armed));

endmodule

bind rx_desc_wb rx_desc_wb_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_wdata  (mem_wdata),
    .rx_running (rx_running),
    .rx_armed   (rx_armed),
    .rx_drop    (rx_drop)
);

// File: tb/rx_desc_wb_test.sv
`timescale 1ns/1ps
module rx_desc_wb_test;

    localparam int AW     = 10;
    localparam int BUFSZ  = 1536;
    localparam int BASE_W = 64;   // word address of the first descriptor

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ring_base = 32'h0000_0100;
    logic        rx_on = 1'b0;
    logic        frame_done = 1'b0;
    logic [15:0] frame_len = '0;
    logic [8:0]  frame_err = '0;
    logic        mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        rx_running, rx_armed, rx_drop;

    logic [31:0] mem [0:(1<<AW)-1];
    int total = 0;
    int fails = 0;
    int drops = 0;
    int wr_count = 0;
    int idx = 0;

    always #4 clk = ~clk;

    rx_desc_wb uut (
        .clk(clk), .rst(rst), .ring_base(ring_base), .rx_on(rx_on),
        .frame_done(frame_done), .frame_len(frame_len), .frame_err(frame_err),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rx_running(rx_running), .rx_armed(rx_armed), .rx_drop(rx_drop)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        if (rx_drop) drops <= drops + 1;
    end

    function automatic logic [31:0] expect_word(input int len, input logic [8:0] e,
                                                 input int bsz, input logic intr);
        logic [31:0] w;
        logic over;
        over = len > bsz;
        w = 32'h8000_0000;
        w[30] = over;
        w[29] = intr;
        w[27] = !over && (e[8:2] == 7'd0);
        w[26] = e[8];
        w[25] = e[7];
        w[22] = e[6] | over;
        w[21:16] = e[5:0];
        w[11:0] = over ? 12'(bsz) : 12'(len);
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int cmd_w(input int k);
        return BASE_W + 4*k + 2;
    endfunction

    function automatic logic [31:0] armed_word(input int k);
        return (k == 1) ? (32'h2000_0000 | BUFSZ) : 32'(BUFSZ);
    endfunction

    task automatic pulse_on();
        @(negedge clk); rx_on = 1'b1;
        @(negedge clk); rx_on = 1'b0;
    endtask

    task automatic send(input int len, input logic [8:0] e, input int cycles);
        @(negedge clk);
        frame_done = 1'b1; frame_len = 16'(len); frame_err = e;
        repeat (cycles) @(negedge clk);
        frame_done = 1'b0; frame_err = '0;
    endtask

    task automatic settle();
        for (int n = 0; n < 30; n++) begin
            if (rx_armed || !rx_running) break;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int a = 0; a < (1<<AW); a++) mem[a] = 32'hDEAD_0000 + a;
        for (int k = 0; k < 4; k++) begin
            mem[BASE_W + 4*k]     = 32'h100 + 16*((k+1)%4);
            mem[BASE_W + 4*k + 1] = 32'h1000 + 32'(k*BUFSZ);
            mem[BASE_W + 4*k + 2] = armed_word(k);
            mem[BASE_W + 4*k + 3] = 32'h0;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: stopped after reset
        check("R1 running", 32'(rx_running), 0);
        check("R1 armed", 32'(rx_armed), 0);
        check("R1 no access", 32'(wr_count), 0);

        // R2: start at ring_base
        pulse_on();
        repeat (4) @(negedge clk);
        check("R2 armed after start", 32'(rx_armed), 1);

        // R8: rx_on while running is ignored
        pulse_on();
        check("R8 still armed", 32'(rx_armed), 1);

        // R3/R4/R5/R6 over a wrapping ring
        for (int n = 0; n < 12; n++) begin
            int len;
            logic [8:0] e;
            len = 60 + int'($urandom % 1477);
            e = ($urandom % 3 == 0) ? 9'($urandom) : 9'd0;
            if (n == 0) begin len = 64;   e = 9'd0;  end
            if (n == 1) begin len = BUFSZ; e = 9'd0; end
            if (n == 2) begin len = BUFSZ + 1; e = 9'd0; end
            if (n == 3) begin len = 200;  e = 9'h040; end
            if (n == 4) begin len = 3000; e = 9'h108; end
            send(len, e, 1);
            settle();
            check($sformatf("R3 R4 R5 R6 frame %0d desc %0d", n, idx),
                  mem[cmd_w(idx)], expect_word(len, e, BUFSZ, idx == 1));
            @(negedge clk);
            mem[cmd_w(idx)] = armed_word(idx);
            idx = (idx + 1) % 4;
        end

        // R9: frame offered while writing back is dropped
        begin
            int d0;
            d0 = drops;
            send(100, 9'd0, 2);
            settle();
            check("R9 first taken", mem[cmd_w(idx)], expect_word(100, 9'd0, BUFSZ, idx == 1));
            check("R9 drop pulse", 32'(drops - d0), 1);
            check("R9 next untouched", mem[cmd_w((idx+1)%4)], armed_word((idx+1)%4));
            @(negedge clk);
            mem[cmd_w(idx)] = armed_word(idx);
            idx = (idx + 1) % 4;
        end

        // R7: next descriptor still owned by software -> stop and drop
        begin
            int d0, nx, w0;
            nx = (idx + 1) % 4;
            mem[cmd_w(nx)] = 32'h8000_0123;
            send(80, 9'd0, 1);
            settle();
            repeat (3) @(negedge clk);
            check("R7 stopped", 32'(rx_running), 0);
            check("R7 wrote current", mem[cmd_w(idx)], expect_word(80, 9'd0, BUFSZ, idx == 1));
            mem[cmd_w(idx)] = armed_word(idx);
            d0 = drops; w0 = wr_count;
            send(90, 9'd0, 1);
            repeat (3) @(negedge clk);
            check("R7 drop while stopped", 32'(drops - d0), 1);
            check("R7 no write while stopped", 32'(wr_count - w0), 0);
            check("R7 owned word kept", mem[cmd_w(nx)], 32'h8000_0123);

            // R8: resume at the stopping descriptor
            mem[cmd_w(nx)] = armed_word(nx);
            pulse_on();
            repeat (4) @(negedge clk);
            check("R8 re-armed", 32'(rx_armed), 1);
            send(333, 9'h003, 1);
            settle();
            check("R8 resumed descriptor", mem[cmd_w(nx)], expect_word(333, 9'h003, BUFSZ, nx == 1));
            if (nx != 0)
                check("R8 base untouched", mem[cmd_w(0)], armed_word(0));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule